// File: doc/BRIEF.md
# Pin Interrupt Detector for an Eight-Line Port

This block turns the synchronized input levels of a small GPIO port into interrupt status bits and one interrupt request line. Each line has its own trigger selection: rising edge, falling edge, either edge, high level or low level. Software programs the trigger selection and a per-line enable through a simple register write port. It reads back status, enable and trigger settings, and it acknowledges events by writing ones to a clear register. The request output is high whenever any enabled line has its status bit set.

Edge events are found by comparing each line with its value one cycle earlier. An edge sets a status bit that stays set until software clears it. Level triggers set the status bit in every cycle the line is at its active level. The bit is therefore set again right after a clear while the level lasts, and it stays set after the level goes away until it is cleared. A clear and a new event in the same cycle leave the bit set, so no edge is lost when software acknowledges before servicing.

Masked aliases let software change only the lines it selects, without a read-modify-write: one field of the written word selects lines and another gives their new value.

Top module: `pid_top`

## Requirements
- R1: After reset, the enable, trigger and status registers read 0 and `irq_o` is low. Every line is then disabled and set to trigger on low level.
- R2: The trigger register at offset 0x060 holds three lanes of NPINS bits. For line n, bit n is the polarity, bit n+8 selects edge mode and bit n+16 selects either-edge. Rising is 0x000101<<n, falling 0x000100<<n, either edge 0x010100<<n, high level 0x000001<<n and low level 0x000000<<n. The register reads back what was written.
- R3: In rising or falling mode, a change of the line against its value one cycle earlier, in the chosen direction, sets status bit n at the next clock edge. A change in the other direction does not set it.
- R4: In either-edge mode, both directions of change set the status bit.
- R5: In level mode, a line at its active level (high for polarity 1, low for polarity 0) sets its status bit each cycle. After a clear the bit is set again while the level persists. Once the level is gone, the bit stays set until it is cleared.
- R6: A status bit set by an edge stays set until software clears it, whatever the line does afterwards.
- R7: Writing to the clear register at offset 0x070 clears each status bit whose data bit is 1 and leaves the bits written as 0 unchanged. The clear register reads as 0.
- R8: If a clear of bit n and a qualifying event on line n fall in the same cycle, status bit n is 1 afterwards.
- R9: `irq_o` is the OR over all lines of status AND enable. It follows the registers in the same cycle.
- R10: Offset 0x800 added to status (0x840), enable (0x850) or trigger (0x860) gives a masked alias. For status and enable, data bits [15:8] select lines and bits [7:0] give their new value. For trigger, bits [31:24] select lines and bits [23:0] give the new lanes. Lines that are not selected keep their old value. The alias reads like the base register.
- R11: A write to the status base offset 0x040 has no effect. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Synchronized line levels |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in exactly the cycle in which a new edge arrives. The stimulus first holds line 0 low in rising mode for one cycle. In the next cycle it raises the line and writes the clear bit for line 0, so the event and the clear meet at the same clock edge. Level re-assertion right after a clear, and masked trigger writes that change the mode of a single line while the others keep theirs, are also driven on purpose. A long stretch of random line patterns mixed with random writes is then compared every cycle against a behavioural model.

// File: rtl/pid_pkg.sv
package pid_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_EN     = 12'h050;
    localparam logic [ADDR_W-1:0] OFS_TRIG   = 12'h060;
    localparam logic [ADDR_W-1:0] OFS_CLR    = 12'h070;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h800;

    typedef struct packed {
        logic en_full;
        logic en_sel;
        logic trig_full;
        logic trig_sel;
        logic stat_sel;
        logic clr;
    } wr_strobe_t;
endpackage

// File: rtl/pid_pin_detect.sv
module pid_pin_detect (
    input  logic cur_i,
    input  logic prev_i,
    input  logic pol_i,
    input  logic edge_i,
    input  logic both_i,
    output logic hit_o
);
    logic rise;
    logic fall;

    always_comb begin
        rise = cur_i & ~prev_i;
        fall = ~cur_i & prev_i;
        if (!edge_i) begin
            hit_o = pol_i ? cur_i : ~cur_i;
        end else if (both_i) begin
            hit_o = rise | fall;
        end else begin
            hit_o = pol_i ? rise : fall;
        end
    end
endmodule

// File: rtl/pid_bus_port.sv
module pid_bus_port
    import pid_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NPINS-1:0]    st_i,
    input  logic [NPINS-1:0]    en_i,
    input  logic [3*NPINS-1:0]  trig_i,
    output wr_strobe_t          wr_o,
    output logic [DATA_W-1:0]   rdata_o
);
    localparam int unsigned TRIG_W = 3 * NPINS;

    logic                masked;
    logic [ADDR_W-1:0]   base;
    logic                sel_stat;
    logic                sel_en;
    logic                sel_trig;
    logic                sel_clr;

    always_comb begin
        masked   = (bus_addr & OFS_MASKED) != '0;
        base     = bus_addr & ~OFS_MASKED;
        sel_stat = base == OFS_STAT;
        sel_en   = base == OFS_EN;
        sel_trig = base == OFS_TRIG;
        sel_clr  = (base == OFS_CLR) && !masked;

        wr_o.en_full   = bus_wr && sel_en   && !masked;
        wr_o.en_sel    = bus_wr && sel_en   &&  masked;
        wr_o.trig_full = bus_wr && sel_trig && !masked;
        wr_o.trig_sel  = bus_wr && sel_trig &&  masked;
        wr_o.stat_sel  = bus_wr && sel_stat &&  masked;
        wr_o.clr       = bus_wr && sel_clr;

        rdata_o = '0;
        if (sel_stat) begin
            rdata_o[NPINS-1:0] = st_i;
        end else if (sel_en) begin
            rdata_o[NPINS-1:0] = en_i;
        end else if (sel_trig) begin
            rdata_o[TRIG_W-1:0] = trig_i;
        end
    end
endmodule

// File: rtl/pid_regfile.sv
module pid_regfile
    import pid_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPINS-1:0]    pin_i,
    input  logic [NPINS-1:0]    hit_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  wr_strobe_t          wr_i,
    output logic [NPINS-1:0]    st_o,
    output logic [NPINS-1:0]    en_o,
    output logic [NPINS-1:0]    prv_o,
    output logic [3*NPINS-1:0]  trig_o
);
    localparam int unsigned TRIG_W = 3 * NPINS;

    typedef struct packed {
        logic [NPINS-1:0]  st;
        logic [NPINS-1:0]  en;
        logic [NPINS-1:0]  prv;
        logic [TRIG_W-1:0] trig;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic [NPINS-1:0]  val;
    logic [NPINS-1:0]  sel;
    logic [TRIG_W-1:0] tval;
    logic [TRIG_W-1:0] tsel;
    logic [NPINS-1:0]  st_base;

    always_comb begin
        val  = wdata_i[NPINS-1:0];
        sel  = wdata_i[2*NPINS-1:NPINS];
        tval = wdata_i[TRIG_W-1:0];
        tsel = {3{wdata_i[TRIG_W+NPINS-1:TRIG_W]}};

        state_d     = state_q;
        state_d.prv = pin_i;

        if (wr_i.en_full) begin
            state_d.en = val;
        end else if (wr_i.en_sel) begin
            state_d.en = (state_q.en & ~sel) | (val & sel);
        end

        if (wr_i.trig_full) begin
            state_d.trig = tval;
        end else if (wr_i.trig_sel) begin
            state_d.trig = (state_q.trig & ~tsel) | (tval & tsel);
        end

        st_base = state_q.st;
        if (wr_i.stat_sel) begin
            st_base = (st_base & ~sel) | (val & sel);
        end
        if (wr_i.clr) begin
            st_base = st_base & ~val;
        end
        state_d.st = st_base | hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign st_o   = state_q.st;
    assign en_o   = state_q.en;
    assign prv_o  = state_q.prv;
    assign trig_o = state_q.trig;
endmodule

// File: rtl/pid_top.sv
module pid_top
    import pid_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPINS-1:0]    pin_i,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq_o
);
    localparam int unsigned TRIG_W = 3 * NPINS;

    wr_strobe_t         wr;
    logic               wr_clr;
    logic               wr_stat_sel;
    logic [NPINS-1:0]   st_q;
    logic [NPINS-1:0]   en_q;
    logic [NPINS-1:0]   prv_q;
    logic [TRIG_W-1:0]  trig_q;
    logic [NPINS-1:0]   hit;

    pid_bus_port #(.NPINS(NPINS)) u_bus (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .st_i     (st_q),
        .en_i     (en_q),
        .trig_i   (trig_q),
        .wr_o     (wr),
        .rdata_o  (bus_rdata)
    );

    assign wr_clr      = wr.clr;
    assign wr_stat_sel = wr.stat_sel;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pid_pin_detect u_det (
            .cur_i  (pin_i[p]),
            .prev_i (prv_q[p]),
            .pol_i  (trig_q[p]),
            .edge_i (trig_q[NPINS+p]),
            .both_i (trig_q[2*NPINS+p]),
            .hit_o  (hit[p])
        );
    end

    pid_regfile #(.NPINS(NPINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .hit_i   (hit),
        .wdata_i (bus_wdata),
        .wr_i    (wr),
        .st_o    (st_q),
        .en_o    (en_q),
        .prv_o   (prv_q),
        .trig_o  (trig_q)
    );

    assign irq_o = |(st_q & en_q);
endmodule

// File: rtl/pid_checker.sv
module pid_checker #(
    parameter int unsigned NPINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPINS-1:0]  st_q,
    input logic [NPINS-1:0]  en_q,
    input logic [NPINS-1:0]  hit,
    input logic              wr_clr,
    input logic              wr_stat_sel,
    input logic [31:0]       bus_wdata,
    input logic              irq_o
);
    // R6: without a clear or masked status write no status bit drops
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_clr && !wr_stat_sel) |=> ((st_q & $past(st_q)) == $past(st_q)));

    // R7: bits written as zero in the clear register survive
    a_r7_zero_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((st_q & $past(st_q & ~bus_wdata[NPINS-1:0]))
                    == $past(st_q & ~bus_wdata[NPINS-1:0])));

    // R8: a qualifying event always leaves its status bit set
    a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((st_q & $past(hit)) == $past(hit)));

    // R9: no request without an enabled line
    a_r9_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o);

    // R9: no request without a status bit
    a_r9_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == '0) |-> !irq_o);
endmodule

bind pid_top pid_checker #(.NPINS(NPINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_q        (st_q),
    .en_q        (en_q),
    .hit         (hit),
    .wr_clr      (wr_clr),
    .wr_stat_sel (wr_stat_sel),
    .bus_wdata   (bus_wdata),
    .irq_o       (irq_o)
);

// File: tb/sim_pid_top.sv
module sim_pid_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_i = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = 12'h040;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference state
    logic [7:0]  m_st = '0;
    logic [7:0]  m_en = '0;
    logic [7:0]  m_prv = '0;
    logic [23:0] m_trig = '0;

    pid_top #(.NPINS(8)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] enc(input int mode, input int p);
        logic [31:0] v;
        case (mode)
            0: v = 32'h000101;
            1: v = 32'h000100;
            2: v = 32'h010100;
            3: v = 32'h000001;
            default: v = 32'h000000;
        endcase
        return v << p;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (a)
            12'h040, 12'h840: return {24'h0, m_st};
            12'h050, 12'h850: return {24'h0, m_en};
            12'h060, 12'h860: return {8'h0, m_trig};
            default:          return 32'h0;
        endcase
    endfunction

    task automatic model_step(input logic [7:0] pins, input logic wr,
                              input logic [11:0] a, input logic [31:0] wd);
        logic [7:0] ev;
        logic [7:0] ns;
        for (int p = 0; p < 8; p++) begin
            bit up = pins[p] && !m_prv[p];
            bit dn = !pins[p] && m_prv[p];
            int code = {m_trig[16+p], m_trig[8+p], m_trig[p]};
            case (code)
                3'b011: ev[p] = up;
                3'b010: ev[p] = dn;
                3'b110, 3'b111: ev[p] = up || dn;
                3'b001, 3'b101: ev[p] = pins[p];
                default: ev[p] = !pins[p];
            endcase
        end
        ns = m_st;
        if (wr) begin
            case (a)
                12'h050: m_en = wd[7:0];
                12'h850: for (int p = 0; p < 8; p++) if (wd[8+p]) m_en[p] = wd[p];
                12'h060: m_trig = wd[23:0];
                12'h860: for (int p = 0; p < 8; p++)
                             if (wd[24+p]) for (int k = 0; k < 3; k++) m_trig[8*k+p] = wd[8*k+p];
                12'h840: for (int p = 0; p < 8; p++) if (wd[8+p]) ns[p] = wd[p];
                12'h070: ns = ns & ~wd[7:0];
                default: ;
            endcase
        end
        m_st = ns | ev;
        m_prv = pins;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic cyc(input logic [7:0] pins, input logic wr, input logic [11:0] a,
                       input logic [31:0] wd, input string req);
        @(negedge clk);
        pin_i = pins; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        @(posedge clk);
        model_step(pins, wr, a, wd);
        #1;
        chk({req, " rdata"}, bus_rdata, model_read(a));
        chk({req, " irq"}, {31'h0, irq_o}, {31'h0, |(m_st & m_en)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired got=hang expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] cfg;
        // R1: state while held in reset
        repeat (3) @(posedge clk);
        #1;
        bus_addr = 12'h040; #1; chk("R1 status", bus_rdata, 0);
        bus_addr = 12'h050; #1; chk("R1 enable", bus_rdata, 0);
        bus_addr = 12'h060; #1; chk("R1 trigger", bus_rdata, 0);
        chk("R1 irq", {31'h0, irq_o}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R5: low level default sets all status bits
        cyc(8'h00, 0, 12'h040, 0, "R5");
        chk("R5 low level", bus_rdata, 32'hFF);
        cyc(8'h00, 1, 12'h050, 32'hFF, "R9");
        chk("R9 irq on", {31'h0, irq_o}, 1);
        cyc(8'h00, 1, 12'h070, 32'hFF, "R7");
        chk("R7 clear reads zero", bus_rdata, 0);
        cyc(8'h00, 0, 12'h040, 0, "R5");
        chk("R5 reassert", bus_rdata, 32'hFF);
        cyc(8'hFF, 0, 12'h040, 0, "R5");
        chk("R5 sticky after level", bus_rdata, 32'hFF);
        cyc(8'hFF, 1, 12'h070, 32'hFF, "R7");
        cyc(8'hFF, 0, 12'h040, 0, "R7");
        chk("R7 cleared", bus_rdata, 0);

        // R2: per-line trigger encodings
        cfg = enc(0,0) | enc(1,1) | enc(2,2) | enc(3,3) | enc(4,4) | enc(0,5) | enc(0,6) | enc(0,7);
        cyc(8'hFF, 1, 12'h060, cfg, "R2");
        chk("R2 readback", bus_rdata, cfg);
        cyc(8'hFF, 0, 12'h040, 0, "R5");
        chk("R5 high level", bus_rdata, 32'h08);
        cyc(8'h00, 0, 12'h040, 0, "R3");
        chk("R3 R4 falling", bus_rdata, 32'h1E);
        cyc(8'hFF, 0, 12'h040, 0, "R6");
        chk("R6 R4 rising", bus_rdata, 32'hFF);
        cyc(8'hFF, 1, 12'h070, 32'hFF, "R6");
        cyc(8'hFF, 0, 12'h040, 0, "R6");
        chk("R6 after clear", bus_rdata, 32'h08);
        cyc(8'hFF, 1, 12'h070, 32'h00, "R7");
        cyc(8'hFF, 0, 12'h040, 0, "R7");
        chk("R7 zero bits", bus_rdata, 32'h08);

        // R8: clear and rising edge meet in one cycle
        cyc(8'hFE, 0, 12'h040, 0, "R8");
        cyc(8'hFF, 1, 12'h070, 32'h01, "R8");
        cyc(8'hFF, 0, 12'h040, 0, "R8");
        chk("R8 event wins", bus_rdata, 32'h09);

        // R10: masked aliases
        cyc(8'hFF, 1, 12'h850, 32'h0F05, "R10");
        chk("R10 enable alias", bus_rdata, 32'hF5);
        cyc(8'hFF, 1, 12'h860, 32'h80000080, "R10");
        chk("R10 trigger alias", bus_rdata, (cfg & ~32'h808080) | 32'h80);

        // R11: status base write ignored
        cyc(8'hFF, 1, 12'h060, 32'h00FFFF, "R11");
        cyc(8'hFF, 1, 12'h070, 32'hFF, "R11");
        cyc(8'hFF, 1, 12'h040, 32'hFF, "R11");
        chk("R11 status base write", bus_rdata, 0);
        cyc(8'hFF, 0, 12'h0A0, 0, "R11");
        chk("R11 unmapped", bus_rdata, 0);
        cyc(8'hFF, 1, 12'h840, 32'h8080, "R10");
        chk("R10 status alias", bus_rdata, 32'h80);
        chk("R9 irq enabled line", {31'h0, irq_o}, 1);
        cyc(8'hFF, 1, 12'h840, 32'h8000, "R10");
        chk("R9 irq off", {31'h0, irq_o}, 0);

        // random mix against the model
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 9);
            logic [7:0] pv = 8'($urandom);
            logic [31:0] rv = $urandom;
            case (op)
                0: cyc(pv, 1, 12'h070, rv, "R7");
                1: cyc(pv, 1, 12'h060, rv, "R2");
                2: cyc(pv, 1, 12'h850, rv, "R10");
                3: cyc(pv, 1, 12'h860, rv, "R10");
                4: cyc(pv, 1, 12'h050, rv, "R9");
                5: cyc(pv, 1, 12'h840, rv, "R10");
                default: cyc(pv, 0, 12'h040, 0, "R3");
            endcase
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule